// File: doc/BRIEF.md
# Operand Stack Top Cache

This block holds the topmost words of a bytecode operand stack in an on-chip circular buffer of 32-bit words. A bottom pointer and an occupancy count locate the live window, and the top of stack is the newest entry in that window. One command port takes push, pop, duplicate-top and exchange-top-two operations. Two combinational read ports and one write port address any entry by its distance from the top. A datapath can therefore use an operand in place, without first moving it to the top.

When occupancy climbs to the high watermark, the oldest word is written out to a backing memory, one word per accepted request. When occupancy falls below the low watermark and spilled words exist, they are read back in last-out-first-in order and placed beneath the current bottom. The memory side is a single valid/ready request with a same-cycle read response. Occupancy and the spilled-word count are exported so that an outside controller can observe the stack depth. A command that needs a word that is still in memory, or that needs room while the buffer is full, is held off with its ready low. A command that needs words the stack does not have at all is flagged as an underflow and dropped.

Top module: `opstack_cache`

## Requirements
- R1: After reset, count_o and spilled_o are 0, mem_req_o is 0 and cmd_ready_o is 1.
- R2: Opcode 0x01 pushes cmd_data_i as the new top, opcode 0x57 removes the top, and opcode 0x59 pushes a copy of the top. count_o changes by +1, -1 and +1 respectively.
- R3: Opcode 0x5F exchanges the two topmost words, so that (..., w2, w1) becomes (..., w1, w2), and leaves count_o unchanged.
- R4: rd_a_data_o and rd_b_data_o return, in the same cycle, the entry at rd_a_off_i and rd_b_off_i words below the top (offset 0 is the top).
- R5: With wr_en_i high, cmd_valid_i low and wr_off_i below count_o, wr_data_i replaces the entry wr_off_i words below the top at the clock edge. While cmd_valid_i is high, the write port is ignored.
- R6: While count_o is at least 56 and spilled_o is below the memory depth, mem_req_o and mem_we_o are high, mem_addr_o equals spilled_o and mem_wdata_o is the oldest entry. Each cycle with mem_ready_i high moves that word out: count_o falls by 1 and spilled_o rises by 1.
- R7: While count_o is below 8 and spilled_o is nonzero, a read is requested (mem_we_o low) at address spilled_o-1. On mem_ready_i, mem_rdata_i becomes the new oldest entry, so that words return in reverse order of spilling.
- R8: A command that needs more entries than count_o while spilled_o is 0 (pop, dup or swap on too shallow a stack) raises underflow_o in that cycle, is accepted with cmd_ready_o high, and changes no state.
- R9: cmd_ready_o is low while a command needs entries that exist only in memory, or while a push or dup meets count_o equal to 64. The command completes once the fill or spill has made it possible.
- R10: The sum count_o + spilled_o changes only in a cycle where a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 8 | Command opcode |
| cmd_data_i | input | 32 | Push operand |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| underflow_o | output | 1 | Current command lacks entries, dropped |
| rd_a_off_i | input | 6 | Read port A offset from top |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_off_i | input | 6 | Read port B offset from top |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Offset write enable |
| wr_off_i | input | 6 | Offset write position from top |
| wr_data_i | input | 32 | Offset write data |
| count_o | output | 7 | Words held on chip |
| spilled_o | output | 11 | Words held in backing memory |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 spill write, 0 fill read |
| mem_addr_o | output | 10 | Memory word address |
| mem_wdata_o | output | 32 | Spill data |
| mem_rdata_i | input | 32 | Fill data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Memory accepts request |

## Verification
On every cycle the assertions check the following. Spill requests appear only at or above the high watermark, and fill requests only below the low watermark with words outstanding. An underflow is always accepted and leaves the counters untouched. A push never passes a full buffer. Words are neither created nor lost while no command is accepted. The data path itself is shown only by the bench scenarios: the actual word order after swap and dup, offset reads and writes, the memory image left by spilling, the strict reverse order of refilled words, and the release of a stalled command once memory answers.

// File: rtl/opstack_pkg.sv
package opstack_pkg;
  localparam logic [7:0] OP_PUSH = 8'h01;
  localparam logic [7:0] OP_POP  = 8'h57;
  localparam logic [7:0] OP_DUP  = 8'h59;
  localparam logic [7:0] OP_SWAP = 8'h5F;
endpackage

// File: rtl/opstack_store.sv
module opstack_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int NW    = 4,
  parameter int NR    = 5,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i   [NW],
  input  logic [IW-1:0] widx_i [NW],
  input  logic [DW-1:0] wdat_i [NW],
  input  logic [IW-1:0] ridx_i [NR],
  output logic [DW-1:0] rdat_o [NR]
);
  logic [DW-1:0] mem_q [DEPTH];

  // higher port index wins on a shared slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else begin
      for (int p = 0; p < NW; p++)
        if (we_i[p]) mem_q[widx_i[p]] <= wdat_i[p];
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rdat_o[r] = mem_q[ridx_i[r]];
  end
endmodule

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
  import opstack_pkg::*;
#(
  parameter int DW        = 32,
  parameter int DEPTH     = 64,
  parameter int HI_MARK   = 56,
  parameter int LO_MARK   = 8,
  parameter int MEM_DEPTH = 1024,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(MEM_DEPTH + 1),
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          cmd_ready_o,
  output logic          underflow_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_off_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] top_dat_i,
  input  logic [DW-1:0] nxt_dat_i,
  input  logic [DW-1:0] bot_dat_i,
  output logic [IW-1:0] top_idx_o,
  output logic [IW-1:0] bot_idx_o,
  output logic          we_o   [4],
  output logic [IW-1:0] widx_o [4],
  output logic [DW-1:0] wdat_o [4],
  output logic [CW-1:0] count_o,
  output logic [SW-1:0] spilled_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i
);
  logic [IW-1:0] bot_q, bot_d, top_idx;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sp_q, sp_d;
  logic [1:0]    need;
  logic          room, inc, dec, lacking, full, fire;
  logic          spill_req, fill_req, spill_do, fill_do;
  logic [SW-1:0] sp_m1;

  assign top_idx = bot_q + cnt_q[IW-1:0] - IW'(1);

  always_comb begin
    need = 2'd0; room = 1'b0; inc = 1'b0; dec = 1'b0;
    unique case (cmd_op_i)
      OP_PUSH: begin room = 1'b1; inc = 1'b1; end
      OP_POP:  begin need = 2'd1; dec = 1'b1; end
      OP_DUP:  begin need = 2'd1; room = 1'b1; inc = 1'b1; end
      OP_SWAP: need = 2'd2;
      default: ;
    endcase
  end

  assign lacking     = CW'(need) > cnt_q;
  assign full        = room && (cnt_q == CW'(DEPTH));
  assign cmd_ready_o = !(lacking && sp_q != '0) && !full;
  assign underflow_o = cmd_valid_i && lacking && (sp_q == '0);
  assign fire        = cmd_valid_i && cmd_ready_o && !underflow_o;

  assign spill_req = (cnt_q >= CW'(HI_MARK)) && (sp_q < SW'(MEM_DEPTH));
  assign fill_req  = (cnt_q < CW'(LO_MARK)) && (sp_q != '0);
  assign spill_do  = spill_req && mem_ready_i;
  assign fill_do   = fill_req && mem_ready_i;
  assign sp_m1     = sp_q - SW'(1);

  assign mem_req_o   = spill_req || fill_req;
  assign mem_we_o    = spill_req;
  assign mem_addr_o  = spill_req ? sp_q[AW-1:0] : sp_m1[AW-1:0];
  assign mem_wdata_o = bot_dat_i;

  // port 0: offset write, 1: fill, 2/3: command
  always_comb begin
    we_o[0]   = wr_en_i && !cmd_valid_i && (CW'(wr_off_i) < cnt_q);
    widx_o[0] = top_idx - wr_off_i;
    wdat_o[0] = wr_data_i;
    we_o[1]   = fill_do;
    widx_o[1] = bot_q - IW'(1);
    wdat_o[1] = mem_rdata_i;
    we_o[2]   = 1'b0;
    widx_o[2] = top_idx + IW'(1);
    wdat_o[2] = cmd_data_i;
    we_o[3]   = 1'b0;
    widx_o[3] = top_idx - IW'(1);
    wdat_o[3] = top_dat_i;
    if (fire) begin
      unique case (cmd_op_i)
        OP_PUSH: we_o[2] = 1'b1;
        OP_DUP:  begin we_o[2] = 1'b1; wdat_o[2] = top_dat_i; end
        OP_SWAP: begin
          we_o[2] = 1'b1; widx_o[2] = top_idx; wdat_o[2] = nxt_dat_i;
          we_o[3] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    sp_d  = sp_q;
    bot_d = bot_q;
    if (fire && inc) cnt_d = cnt_d + CW'(1);
    if (fire && dec) cnt_d = cnt_d - CW'(1);
    if (spill_do) begin
      cnt_d = cnt_d - CW'(1); sp_d = sp_q + SW'(1); bot_d = bot_q + IW'(1);
    end
    if (fill_do) begin
      cnt_d = cnt_d + CW'(1); sp_d = sp_m1; bot_d = bot_q - IW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sp_q  <= '0;
      bot_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sp_q  <= sp_d;
      bot_q <= bot_d;
    end
  end

  assign top_idx_o = top_idx;
  assign bot_idx_o = bot_q;
  assign count_o   = cnt_q;
  assign spilled_o = sp_q;
endmodule

// File: rtl/opstack_cache.sv
module opstack_cache #(
  parameter int DW        = 32,
  parameter int DEPTH     = 64,
  parameter int HI_MARK   = 56,
  parameter int LO_MARK   = 8,
  parameter int MEM_DEPTH = 1024,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(MEM_DEPTH + 1),
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          cmd_ready_o,
  output logic          underflow_o,
  input  logic [IW-1:0] rd_a_off_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [IW-1:0] rd_b_off_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_off_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [CW-1:0] count_o,
  output logic [SW-1:0] spilled_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i
);
  localparam int NW = 4;
  localparam int NR = 5;

  logic          we   [NW];
  logic [IW-1:0] widx [NW];
  logic [DW-1:0] wdat [NW];
  logic [IW-1:0] ridx [NR];
  logic [DW-1:0] rdat [NR];
  logic [IW-1:0] top_idx, bot_idx;

  // read ports: A, B, top, top-1, oldest
  assign ridx[0] = top_idx - rd_a_off_i;
  assign ridx[1] = top_idx - rd_b_off_i;
  assign ridx[2] = top_idx;
  assign ridx[3] = top_idx - IW'(1);
  assign ridx[4] = bot_idx;
  assign rd_a_data_o = rdat[0];
  assign rd_b_data_o = rdat[1];

  opstack_ctrl #(
    .DW(DW), .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .MEM_DEPTH(MEM_DEPTH)
  ) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_data_i, .cmd_ready_o, .underflow_o,
    .wr_en_i, .wr_off_i, .wr_data_i,
    .top_dat_i (rdat[2]),
    .nxt_dat_i (rdat[3]),
    .bot_dat_i (rdat[4]),
    .top_idx_o (top_idx),
    .bot_idx_o (bot_idx),
    .we_o      (we),
    .widx_o    (widx),
    .wdat_o    (wdat),
    .count_o, .spilled_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ready_i
  );

  opstack_store #(.DW(DW), .DEPTH(DEPTH), .NW(NW), .NR(NR)) u_store (
    .clk_i, .rst_ni,
    .we_i   (we),
    .widx_i (widx),
    .wdat_i (wdat),
    .ridx_i (ridx),
    .rdat_o (rdat)
  );
endmodule

// File: rtl/opstack_cache_chk.sv
module opstack_cache_chk #(
  parameter int DEPTH     = 64,
  parameter int HI_MARK   = 56,
  parameter int LO_MARK   = 8,
  parameter int MEM_DEPTH = 1024,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(MEM_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [7:0]    cmd_op_i,
  input logic          cmd_ready_o,
  input logic          underflow_o,
  input logic [CW-1:0] count_o,
  input logic [SW-1:0] spilled_o,
  input logic          mem_req_o,
  input logic          mem_we_o
);
  logic [SW:0] total;
  assign total = (SW+1)'(count_o) + (SW+1)'(spilled_o);

  AST_SPILL_AT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> count_o >= CW'(HI_MARK)); // R6
  AST_FILL_AT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> (count_o < CW'(LO_MARK)) && (spilled_o != '0)); // R7
  AST_UNDERFLOW_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> cmd_ready_o); // R8
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> $stable(count_o) && $stable(spilled_o)); // R8
  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == 8'h01 && count_o == CW'(DEPTH) |-> !cmd_ready_o); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R9
  AST_WORDS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_ready_o) |=> $stable(total)); // R10
endmodule

bind opstack_cache opstack_cache_chk #(
  .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .MEM_DEPTH(MEM_DEPTH)
) u_chk (
  .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_ready_o, .underflow_o,
  .count_o, .spilled_o, .mem_req_o, .mem_we_o
);

// File: tb/opstack_cache_tb.sv
`timescale 1ns/1ps
module opstack_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready, underflow;
  logic [5:0]  rd_a_off = '0, rd_b_off = '0;
  logic [31:0] rd_a_data, rd_b_data;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_off = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  count;
  logic [10:0] spilled;
  logic        mem_req, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_rdy = 1'b1;
  logic [31:0] bmem [1024];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opstack_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .cmd_ready_o(cmd_ready), .underflow_o(underflow),
    .rd_a_off_i(rd_a_off), .rd_a_data_o(rd_a_data), .rd_b_off_i(rd_b_off),
    .rd_b_data_o(rd_b_data), .wr_en_i(wr_en), .wr_off_i(wr_off), .wr_data_i(wr_data),
    .count_o(count), .spilled_o(spilled), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_rdy)
  );

  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) if (mem_req && mem_we && mem_rdy) bmem[mem_addr] <= mem_wdata;

  localparam logic [7:0] PUSH = 8'h01, POP = 8'h57, DUP = 8'h59, SWAP = 8'h5F;
  // {op, data, expected top, expected count}
  localparam logic [79:0] VEC [8] = '{
    {PUSH, 32'h11, 32'h11, 8'd1},
    {PUSH, 32'h22, 32'h22, 8'd2},
    {DUP,  32'h0,  32'h22, 8'd3},
    {PUSH, 32'h33, 32'h33, 8'd4},
    {SWAP, 32'h0,  32'h22, 8'd4},
    {POP,  32'h0,  32'h33, 8'd3},
    {POP,  32'h0,  32'h22, 8'd2},
    {POP,  32'h0,  32'h11, 8'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // issue one command, waiting out stalls; top_seen is the top when it fires
  task automatic issue(input logic [7:0] op, input logic [31:0] d, output logic [31:0] top_seen);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; rd_a_off = '0;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    top_seen = rd_a_data;
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      summary();
    end
  end

  initial begin
    logic [31:0] t;
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 count", 32'(count), 0);
    check("R1 spilled", 32'(spilled), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 ready", 32'(cmd_ready), 1);

    // vector table: R2 push/pop/dup, R3 swap
    for (int v = 0; v < 8; v++) begin
      issue(VEC[v][79:72], VEC[v][71:40], t);
      rd_a_off = '0;
      #1;
      check("R2/R3 top", rd_a_data, VEC[v][39:8]);
      check("R2/R3 count", 32'(count), 32'(VEC[v][7:0]));
    end
    issue(POP, 0, t);
    check("R2 empty", 32'(count), 0);

    // R8 underflow on empty pop
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = POP; #1;
    check("R8 flag", 32'(underflow), 1);
    check("R8 ready", 32'(cmd_ready), 1);
    @(negedge clk); cmd_valid = 1'b0; #1;
    check("R8 count", 32'(count), 0);
    issue(PUSH, 32'h55, t);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = SWAP; #1;
    check("R8 swap flag", 32'(underflow), 1);
    @(negedge clk); cmd_valid = 1'b0; #1;
    rd_a_off = '0; #1;
    check("R8 swap top", rd_a_data, 32'h55);
    check("R8 swap count", 32'(count), 1);
    issue(POP, 0, t);

    // R4 offset reads
    for (int i = 0; i < 4; i++) issue(PUSH, 32'hA0 + 32'(i), t);
    rd_a_off = 6'd3; rd_b_off = 6'd1; #1;
    check("R4 port A", rd_a_data, 32'hA0);
    check("R4 port B", rd_b_data, 32'hA2);

    // R5 offset write, then ignored under a command
    @(negedge clk);
    wr_en = 1'b1; wr_off = 6'd2; wr_data = 32'hBEEF;
    @(negedge clk); wr_en = 1'b0;
    rd_a_off = 6'd2; #1;
    check("R5 write", rd_a_data, 32'hBEEF);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = PUSH; cmd_data = 32'hC0;
    wr_en = 1'b1; wr_off = 6'd0; wr_data = 32'hDEAD;
    @(negedge clk);
    cmd_valid = 1'b0; wr_en = 1'b0;
    rd_a_off = 6'd0; rd_b_off = 6'd1; #1;
    check("R5 ignored top", rd_a_data, 32'hC0);
    check("R5 ignored old", rd_b_data, 32'hA3);
    for (int i = 0; i < 5; i++) issue(POP, 0, t);
    check("R5 drained", 32'(count), 0);

    // R6 spill with memory always ready
    mem_rdy = 1'b1;
    for (int i = 0; i < 70; i++) issue(PUSH, 32'h100 + 32'(i), t);
    repeat (12) @(negedge clk);
    #1;
    check("R6 count", 32'(count), 55);
    check("R6 spilled", 32'(spilled), 15);
    check("R6 mem first", bmem[0], 32'h100);
    check("R6 mem last", bmem[14], 32'h10E);
    check("R10 total", 32'(count) + 32'(spilled), 70);

    // R7 fill back in reverse order
    for (int i = 0; i < 70; i++) begin
      issue(POP, 0, t);
      check("R7 pop order", t, 32'h100 + 32'(69 - i));
    end
    check("R7 count", 32'(count), 0);
    check("R7 spilled", 32'(spilled), 0);

    // R9 stall on full with memory blocked
    mem_rdy = 1'b0;
    for (int i = 0; i < 64; i++) issue(PUSH, 32'h200 + 32'(i), t);
    check("R9 full", 32'(count), 64);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = PUSH; cmd_data = 32'h240; #1;
    check("R9 push stalled", 32'(cmd_ready), 0);
    repeat (3) @(negedge clk);
    #1;
    check("R9 still stalled", 32'(cmd_ready), 0);
    check("R10 held", 32'(count) + 32'(spilled), 64);
    mem_rdy = 1'b1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk); cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    check("R9 released count", 32'(count), 55);
    check("R9 released spilled", 32'(spilled), 10);

    // R9 stall on pop needing a spilled word
    mem_rdy = 1'b0;
    for (int i = 0; i < 55; i++) issue(POP, 0, t);
    check("R9 drained", 32'(count), 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = POP; #1;
    check("R9 pop stalled", 32'(cmd_ready), 0);
    check("R9 no underflow", 32'(underflow), 0);
    mem_rdy = 1'b1;
    @(negedge clk); #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    rd_a_off = '0; #1;
    check("R9 refilled top", rd_a_data, 32'h209);
    @(negedge clk); cmd_valid = 1'b0;
    for (int i = 0; i < 9; i++) begin
      issue(POP, 0, t);
      check("R7 refill order", t, 32'h208 - 32'(i));
    end
    repeat (3) @(negedge clk);
    #1;
    check("R7 final count", 32'(count), 0);
    check("R7 final spilled", 32'(spilled), 0);

    done = 1'b1;
    summary();
  end
endmodule